// File: doc/BRIEF.md
# Defect-Triggered PLL Mode Controller

This block picks which clock-recovery loop a disc front end should use. When a surface defect appears, the analog loop can lose lock, and a digital loop has to take over. The controller watches a defect-detection level and measures how long it lasts in frame periods. Once the defect has lasted long enough, the controller selects the digital loop. After the defect clears, it keeps the digital loop for a programmable hold interval and then returns to the analog loop. A single defect event therefore gives the sequence analog, digital, analog.

The defect level arrives asynchronously and passes through a synchronizer before it is used. All decisions are taken on a one-cycle frame strobe. The select output therefore changes only in the clock that follows a strobe. The switch-over threshold is chosen by one bit. The hold interval is set by a small field.

Top module: `dpll_defect_ctl`

## Requirements
- R1: While `rst_n` is low, `pll_dig` is 0. Reset clears both the defect-length count and the hold count. After reset, three high defect frames with `thr_sel`=0 leave `pll_dig` at 0, even if high frames were counted before the reset.
- R2: While the synchronized defect level is low and the controller is in the analog state, `pll_dig` stays 0.
- R3: With `thr_sel`=0, `pll_dig` rises after the 4th consecutive frame strobe at which the synchronized defect level is high. It stays 0 after the 1st to 3rd such strobes.
- R4: With `thr_sel`=1, `pll_dig` rises after the 8th consecutive high-defect frame strobe. It stays 0 after the 1st to 7th.
- R5: A frame strobe that sees the defect low while in the analog state clears the defect-length count. Runs shorter than the threshold, separated by a low frame, never cause a switch.
- R6: `hold_sel`=h (0..7) gives a hold of h+1 frames. After the defect ends, `pll_dig` stays 1 after the 1st to (h+1)th low-defect strobes. It returns to 0 after the (h+2)th.
- R7: If the defect is seen high again during the hold interval, `pll_dig` stays 1. The hold count then restarts from zero at the next low-defect strobe.
- R8: `pll_dig` changes value only in the clock cycle immediately after a cycle with `frame_stb`=1.
- R9: `defect_in` goes through a two-flop synchronizer. A rise applied less than two clock edges before a strobe edge is not counted at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse once per frame period |
| defect_in | input | 1 | Asynchronous defect-detection level, 1 = defect |
| thr_sel | input | 1 | Switch threshold: 0 = 4 frames, 1 = 8 frames |
| hold_sel | input | HOLD_W | Hold interval after the defect, value h gives h+1 frames |
| pll_dig | output | 1 | 1 = digital PLL selected, 0 = analog PLL selected |

## Verification
A change on `defect_in` is usable two rising edges later, because of the synchronizer. A strobe is acted on at its own rising edge, and `pll_dig` reflects that decision one clock after the strobe. The bench changes `defect_in` three cycles before each strobe and compares `pll_dig` at the falling edge that follows the strobe. At every quiet falling edge between strobes, it confirms that `pll_dig` has not moved. A dedicated case raises the defect one half cycle before a strobe edge, to show that the synchronizer delay drops that frame from the count. The expected select value for each frame comes from the run lengths: the high-run index against 4 or 8, and the low-run index against h+1.

// File: rtl/dpll_ctl_pkg.sv
package dpll_ctl_pkg;

   typedef enum logic [1:0] {
      MODE_ANA  = 2'd0,
      MODE_DIG  = 2'd1,
      MODE_HOLD = 2'd2
   } mode_e;

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dpll_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dpll_frame_ctr.sv
module dpll_frame_ctr #(
   parameter int W        = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dpll_frame_ctr: W must be at least 1");
      end
   endgenerate

   logic at_top;

   generate
      if (SATURATE) begin : g_sat
         assign at_top = &cnt;
      end else begin : g_wrap
         assign at_top = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (inc && !at_top) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
   import dpll_ctl_pkg::*;
#(
   parameter int HOLD_W = 3,
   parameter int DCNT_W = 4,
   parameter int HCNT_W = 4,
   parameter int THR_LO = 4,
   parameter int THR_HI = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              def_s,
   input  logic              thr_sel,
   input  logic [HOLD_W-1:0] hold_sel,
   input  logic [DCNT_W-1:0] dcnt,
   input  logic [HCNT_W-1:0] hcnt,
   output logic              d_inc,
   output logic              d_clr,
   output logic              h_inc,
   output logic              h_clr,
   output logic              pll_dig
);
   localparam int DW1 = DCNT_W + 1;
   localparam logic [DW1-1:0] THR_LO_V = DW1'(THR_LO);
   localparam logic [DW1-1:0] THR_HI_V = DW1'(THR_HI);

   mode_e            st, nxt;
   logic [DW1-1:0]   thr;
   logic [DW1-1:0]   run_next;
   logic [HCNT_W-1:0] hold_lim;

   assign thr      = thr_sel ? THR_HI_V : THR_LO_V;
   assign run_next = {1'b0, dcnt} + 1'b1;
   assign hold_lim = HCNT_W'(hold_sel) + 1'b1;

   always_comb begin
      nxt   = st;
      d_inc = 1'b0;
      d_clr = 1'b0;
      h_inc = 1'b0;
      h_clr = 1'b0;
      unique case (st)
         MODE_ANA: begin
            if (frame_stb) begin
               if (def_s) begin
                  if (run_next >= thr) begin
                     nxt   = MODE_DIG;
                     d_clr = 1'b1;
                  end else begin
                     d_inc = 1'b1;
                  end
               end else begin
                  d_clr = 1'b1;
               end
            end
         end
         MODE_DIG: begin
            if (frame_stb && !def_s) begin
               nxt   = MODE_HOLD;
               h_inc = 1'b1;
            end
         end
         MODE_HOLD: begin
            if (frame_stb) begin
               if (def_s) begin
                  nxt   = MODE_DIG;
                  h_clr = 1'b1;
               end else if (hcnt == hold_lim) begin
                  nxt   = MODE_ANA;
                  h_clr = 1'b1;
               end else begin
                  h_inc = 1'b1;
               end
            end
         end
         default: begin
            nxt   = MODE_ANA;
            d_clr = 1'b1;
            h_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= MODE_ANA;
      else        st <= nxt;
   end

   assign pll_dig = (st != MODE_ANA);
endmodule

// File: rtl/dpll_defect_ctl.sv
module dpll_defect_ctl #(
   parameter int HOLD_W      = 3,
   parameter int THR_LO      = 4,
   parameter int THR_HI      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              defect_in,
   input  logic              thr_sel,
   input  logic [HOLD_W-1:0] hold_sel,
   output logic              pll_dig
);
   localparam int DCNT_W = $clog2(THR_HI + 1);
   localparam int HCNT_W = HOLD_W + 1;

   generate
      if (THR_LO < 1 || THR_HI < THR_LO) begin : g_bad_thr
         $error("dpll_defect_ctl: need 1 <= THR_LO <= THR_HI");
      end
      if (HOLD_W < 1) begin : g_bad_hold
         $error("dpll_defect_ctl: HOLD_W must be at least 1");
      end
   endgenerate

   logic              def_s;
   logic              d_inc, d_clr, h_inc, h_clr;
   logic [DCNT_W-1:0] dcnt;
   logic [HCNT_W-1:0] hcnt;

   dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (defect_in),
      .q_sync  (def_s)
   );

   dpll_frame_ctr #(.W(DCNT_W), .SATURATE(1'b1)) u_run_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (d_clr),
      .inc   (d_inc),
      .cnt   (dcnt)
   );

   dpll_frame_ctr #(.W(HCNT_W), .SATURATE(1'b1)) u_hold_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (h_clr),
      .inc   (h_inc),
      .cnt   (hcnt)
   );

   dpll_mode_fsm #(
      .HOLD_W (HOLD_W),
      .DCNT_W (DCNT_W),
      .HCNT_W (HCNT_W),
      .THR_LO (THR_LO),
      .THR_HI (THR_HI)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .def_s     (def_s),
      .thr_sel   (thr_sel),
      .hold_sel  (hold_sel),
      .dcnt      (dcnt),
      .hcnt      (hcnt),
      .d_inc     (d_inc),
      .d_clr     (d_clr),
      .h_inc     (h_inc),
      .h_clr     (h_clr),
      .pll_dig   (pll_dig)
   );
endmodule

// File: rtl/dpll_defect_ctl_chk.sv
module dpll_defect_ctl_chk #(
   parameter int DCNT_W = 4,
   parameter int THR_LO = 4,
   parameter int THR_HI = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic              thr_sel,
   input logic              def_s,
   input logic [DCNT_W-1:0] dcnt,
   input logic              pll_dig
);
   p_reset_analog_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pll_dig);

   p_idle_analog_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!def_s && !pll_dig) |=> !pll_dig);

   p_thr_reached_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_dig) |-> (int'($past(dcnt)) + 1 >= ($past(thr_sel) ? THR_HI : THR_LO)));

   p_thr_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pll_dig) && $past(thr_sel)) |-> (int'($past(dcnt)) >= THR_HI - 1));

   p_release_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_dig) |-> ($past(frame_stb) && !$past(def_s)));

   p_retrigger_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && def_s && pll_dig) |=> pll_dig);

   p_stb_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(pll_dig));

   p_switch_needs_defect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_dig) |-> ($past(frame_stb) && $past(def_s)));
endmodule

bind dpll_defect_ctl dpll_defect_ctl_chk #(
   .DCNT_W (DCNT_W),
   .THR_LO (THR_LO),
   .THR_HI (THR_HI)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_stb (frame_stb),
   .thr_sel   (thr_sel),
   .def_s     (def_s),
   .dcnt      (dcnt),
   .pll_dig   (pll_dig)
);

// File: tb/dpll_defect_ctl_tb_top.sv
module dpll_defect_ctl_tb_top;
   localparam int CLK_P  = 10;
   localparam int HOLD_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_stb = 1'b0;
   logic              defect_in = 1'b0;
   logic              thr_sel = 1'b0;
   logic [HOLD_W-1:0] hold_sel = '0;
   logic              pll_dig;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic last_sel = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dpll_defect_ctl #(.HOLD_W(HOLD_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .defect_in (defect_in),
      .thr_sel   (thr_sel),
      .hold_sel  (hold_sel),
      .pll_dig   (pll_dig)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: pll_dig=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // One frame: defect level set three edges before the strobe edge.
   // Quiet cycles must keep pll_dig unchanged (R8); the result is read
   // at the falling edge right after the strobe edge.
   task automatic frame(input logic d, input logic exp, input string req);
      @(negedge clk);
      defect_in = d;
      check("R8 quiet", pll_dig, last_sel);
      repeat (2) begin
         @(negedge clk);
         check("R8 quiet", pll_dig, last_sel);
      end
      @(negedge clk);
      check("R8 quiet", pll_dig, last_sel);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      check(req, pll_dig, exp);
      last_sel = exp;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      defect_in = 1'b0;
      frame_stb = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 in reset", pll_dig, 1'b0);
      last_sel = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, act=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset value", pll_dig, 1'b0);
      rst_n = 1'b1;

      // R2: idle with defect low
      thr_sel = 1'b0;
      hold_sel = 3'd2;
      for (int k = 0; k < 6; k++) frame(1'b0, 1'b0, "R2 idle");

      // Sweep R3/R4/R6 over both thresholds, every hold value, run lengths 1..10
      for (int ts = 0; ts < 2; ts++) begin
         for (int h = 0; h < 8; h++) begin
            for (int len = 1; len <= 10; len++) begin
               int thr;
               thr = (ts != 0) ? 8 : 4;
               thr_sel = ts[0];
               hold_sel = h[HOLD_W-1:0];
               for (int k = 1; k <= len; k++)
                  frame(1'b1, (k >= thr) ? 1'b1 : 1'b0, (ts != 0) ? "R4 threshold" : "R3 threshold");
               for (int j = 1; j <= 10; j++)
                  frame(1'b0, ((len >= thr) && (j <= h + 1)) ? 1'b1 : 1'b0, "R6 hold");
            end
         end
      end

      // R5: short runs split by a low frame never switch
      thr_sel = 1'b0;
      hold_sel = 3'd0;
      for (int k = 0; k < 3; k++) frame(1'b1, 1'b0, "R5 short run");
      frame(1'b0, 1'b0, "R5 clear");
      for (int k = 0; k < 3; k++) frame(1'b1, 1'b0, "R5 short run");
      frame(1'b0, 1'b0, "R5 clear");
      thr_sel = 1'b1;
      for (int k = 0; k < 7; k++) frame(1'b1, 1'b0, "R5 short run hi");
      frame(1'b0, 1'b0, "R5 clear hi");
      for (int k = 0; k < 7; k++) frame(1'b1, 1'b0, "R5 short run hi");
      frame(1'b0, 1'b0, "R5 clear hi");

      // R7: retrigger during hold keeps digital and restarts the hold
      thr_sel = 1'b0;
      hold_sel = 3'd2;
      for (int k = 1; k <= 5; k++) frame(1'b1, (k >= 4) ? 1'b1 : 1'b0, "R7 enter");
      frame(1'b0, 1'b1, "R7 hold");
      frame(1'b0, 1'b1, "R7 hold");
      frame(1'b1, 1'b1, "R7 retrigger");
      frame(1'b1, 1'b1, "R7 retrigger");
      for (int j = 1; j <= 6; j++) frame(1'b0, (j <= 3) ? 1'b1 : 1'b0, "R7 hold restart");

      // R9: rise half a cycle before the strobe edge is not counted
      thr_sel = 1'b0;
      @(negedge clk);
      defect_in = 1'b1;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      check("R9 late rise", pll_dig, 1'b0);
      for (int k = 1; k <= 3; k++) frame(1'b1, 1'b0, "R9 late rise not counted");
      frame(1'b1, 1'b1, "R9 switch on 4th counted");
      for (int j = 1; j <= 5; j++) frame(1'b0, (j <= 3) ? 1'b1 : 1'b0, "R9 release");

      // R1: reset from digital, then the counters must start empty
      for (int k = 1; k <= 4; k++) frame(1'b1, (k >= 4) ? 1'b1 : 1'b0, "R1 setup");
      do_reset();
      check("R1 after reset", pll_dig, 1'b0);
      for (int k = 0; k < 3; k++) frame(1'b1, 1'b0, "R1 run count");
      do_reset();
      for (int k = 0; k < 3; k++) frame(1'b1, 1'b0, "R1 counters cleared");
      frame(1'b0, 1'b0, "R1 idle");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule